// File: doc/BRIEF.md
# Pulse-Interval Frame Decoder

This block sits on the receive path of a contactless tag. A reader sends data by briefly dropping its carrier, and the front end turns the carrier envelope into a single logic level, `env_in`. The decoder times the gap between successive low-to-high transitions of that level, counted in clock cycles. A long gap means a one, a short gap means a zero, and a gap outside both tolerance windows carries no data. The symbols are collected into a frame, least significant bit first.

A frame is closed once the line has stayed quiet for longer than the longest legal symbol. If the frame holds more than the minimum number of bits, the decoder presents it on a one-cycle output. The output has a valid line and no ready line. A frame cannot be held back, because the reader does not pause for the tag. The consumer must therefore capture `frm_data` and `frm_bits` in the cycle that `frm_valid` is high. Both values then stay unchanged until the next frame is emitted. After a long idle period the interval counter stops, so it cannot wrap around into a false symbol.

Top module: `pp_frame_decoder`

## Requirements
- R1: While reset is applied, and after its release, `frm_valid`, `frm_data` and `frm_bits` are all zero until the first frame is emitted.
- R2: The interval is the number of clock edges between the edge that samples one rising transition of `env_in` and the edge that samples the next. An interval strictly between 130 and 170 is decoded as a 1.
- R3: An interval strictly between 70 and 110 is decoded as a 0. Intervals of exactly 70, 110, 130 or 170 are not symbols.
- R4: A rising transition whose interval fits neither window appends nothing. It restarts the timing, and an open frame stays open.
- R5: An open frame closes when 170 clock edges pass after the last sampled rising transition. `frm_valid` is high in the cycle after that 170th edge.
- R6: A closed frame of 4 bits or fewer is dropped, and `frm_valid` stays low. A frame of 5 bits is emitted.
- R7: The first decoded symbol of a frame lands in `frm_data` bit 0, the next in bit 1, and so on.
- R8: A frame keeps at most 32 bits. Later symbols are dropped, `frm_bits` reports 32, and `frm_data` holds the first 32 symbols.
- R9: `frm_valid` lasts exactly one cycle, and the next frame starts empty.
- R10: After 3000 clock edges with no rising transition the interval counter halts. The first rising transition that follows decodes as no symbol, however long the idle period was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| env_in | input | 1 | Thresholded carrier envelope, synchronous to clk, idle high |
| frm_valid | output | 1 | One-cycle strobe: a frame is presented |
| frm_data | output | 32 | Frame symbols, first symbol in bit 0; upper bits zero for short frames |
| frm_bits | output | 6 | Number of symbols in the presented frame |

## Verification
The assertions assume that `env_in` is already synchronous to `clk` and changes only between clock edges. They also assume the input stays low for at least one cycle per pause, so that every rising transition is seen exactly once. The bench drives `env_in` on falling clock edges and uses a fixed 20-cycle pause. The shortest interval it produces is 70 cycles, well above the pause, so every edge it generates is a clean and countable transition.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef enum logic [1:0] {
    SYM_NONE = 2'd0,
    SYM_ZERO = 2'd1,
    SYM_ONE  = 2'd2
  } sym_e;
endpackage

// File: rtl/pp_edge_detect.sv
module pp_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic env_in,
  output logic rise
);
  logic prev_q;

  // line idles high (carrier on), so reset to 1 avoids a false edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= env_in;
  end

  assign rise = env_in & ~prev_q;
endmodule

// File: rtl/pp_interval_timer.sv
module pp_interval_timer #(
  parameter int IDLE_TICKS = 3000,
  parameter int CW         = $clog2(IDLE_TICKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise,
  output logic [CW-1:0] cnt_q
);
  localparam logic [CW-1:0] IDLE = CW'(IDLE_TICKS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= IDLE;
    else if (rise)          cnt_q <= CW'(1);
    else if (cnt_q != IDLE) cnt_q <= cnt_q + CW'(1);
  end

  assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> cnt_q == CW'(1));

  assert_idle_halt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise && cnt_q == IDLE) |=> $stable(cnt_q));
endmodule

// File: rtl/pp_window_match.sv
module pp_window_match #(
  parameter int CW     = 12,
  parameter int CENTER = 150,
  parameter int FUZZ   = 20
) (
  input  logic [CW-1:0] interval,
  output logic          hit
);
  localparam logic [CW-1:0] LO = CW'(CENTER - FUZZ);
  localparam logic [CW-1:0] HI = CW'(CENTER + FUZZ);

  assign hit = (interval > LO) && (interval < HI);
endmodule

// File: rtl/pp_symbol_classify.sv
module pp_symbol_classify
  import pp_pkg::*;
#(
  parameter int CW     = 12,
  parameter int T_ONE  = 150,
  parameter int T_ZERO = 90,
  parameter int FUZZ   = 20
) (
  input  logic [CW-1:0] interval,
  output sym_e          sym
);
  logic [1:0] hit;

  // window 0 decodes a zero, window 1 decodes a one
  for (genvar k = 0; k < 2; k++) begin : g_win
    localparam int CTR = (k == 0) ? T_ZERO : T_ONE;
    pp_window_match #(.CW(CW), .CENTER(CTR), .FUZZ(FUZZ)) u_win (
      .interval(interval),
      .hit     (hit[k])
    );
  end

  always_comb begin
    if (hit[1])      sym = SYM_ONE;
    else if (hit[0]) sym = SYM_ZERO;
    else             sym = SYM_NONE;
  end
endmodule

// File: rtl/pp_frame_accum.sv
module pp_frame_accum
  import pp_pkg::*;
#(
  parameter int CW       = 12,
  parameter int MAX_BITS = 32,
  parameter int MIN_BITS = 4,
  parameter int TIMEOUT  = 170,
  parameter int NW       = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rise,
  input  sym_e                sym,
  input  logic [CW-1:0]       cnt,
  output logic                frm_valid,
  output logic [MAX_BITS-1:0] frm_data,
  output logic [NW-1:0]       frm_bits
);
  localparam int IW = $clog2(MAX_BITS);

  logic                active_q;
  logic [MAX_BITS-1:0] acc_q;
  logic [NW-1:0]       n_q;
  logic                close_now;
  logic                take;

  assign close_now = active_q && (cnt >= CW'(TIMEOUT));
  assign take      = rise && (sym != SYM_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      acc_q     <= '0;
      n_q       <= '0;
      frm_valid <= 1'b0;
      frm_data  <= '0;
      frm_bits  <= '0;
    end else begin
      frm_valid <= 1'b0;
      if (close_now) begin
        if (n_q > NW'(MIN_BITS)) begin
          frm_valid <= 1'b1;
          frm_data  <= acc_q;
          frm_bits  <= n_q;
        end
        acc_q    <= '0;
        n_q      <= '0;
        active_q <= 1'b0;
      end else if (take) begin
        active_q <= 1'b1;
        if (n_q < NW'(MAX_BITS)) begin
          acc_q[n_q[IW-1:0]] <= (sym == SYM_ONE);
          n_q                <= n_q + NW'(1);
        end
      end
    end
  end

  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> !frm_valid);

  assert_accum_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |-> (n_q == '0) && !active_q);

  assert_short_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |-> frm_bits > NW'(MIN_BITS));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    n_q <= NW'(MAX_BITS));

  assert_lsb_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !close_now && n_q < NW'(MAX_BITS))
      |=> acc_q[$past(n_q[IW-1:0])] == $past(sym == SYM_ONE));

  assert_timeout_close_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && cnt >= CW'(TIMEOUT)) |=> !active_q);
endmodule

// File: rtl/pp_frame_decoder.sv
module pp_frame_decoder
  import pp_pkg::*;
#(
  parameter int T_ONE     = 150,
  parameter int T_ZERO    = 90,
  parameter int FUZZ      = 20,
  parameter int IDLE_MULT = 20,
  parameter int MAX_BITS  = 32,
  parameter int MIN_BITS  = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           env_in,
  output logic                           frm_valid,
  output logic [MAX_BITS-1:0]            frm_data,
  output logic [$clog2(MAX_BITS+1)-1:0]  frm_bits
);
  localparam int TIMEOUT    = T_ONE + FUZZ;
  localparam int IDLE_TICKS = IDLE_MULT * T_ONE;
  localparam int CW         = $clog2(IDLE_TICKS + 1);
  localparam int NW         = $clog2(MAX_BITS + 1);

  logic          rise;
  logic [CW-1:0] cnt;
  sym_e          sym;

  pp_edge_detect u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .env_in(env_in),
    .rise  (rise)
  );

  pp_interval_timer #(.IDLE_TICKS(IDLE_TICKS), .CW(CW)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .rise (rise),
    .cnt_q(cnt)
  );

  pp_symbol_classify #(.CW(CW), .T_ONE(T_ONE), .T_ZERO(T_ZERO), .FUZZ(FUZZ)) u_cls (
    .interval(cnt),
    .sym     (sym)
  );

  pp_frame_accum #(
    .CW(CW), .MAX_BITS(MAX_BITS), .MIN_BITS(MIN_BITS), .TIMEOUT(TIMEOUT), .NW(NW)
  ) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise     (rise),
    .sym      (sym),
    .cnt      (cnt),
    .frm_valid(frm_valid),
    .frm_data (frm_data),
    .frm_bits (frm_bits)
  );
endmodule

// File: tb/tb_pp_frame_decoder.sv
module tb_pp_frame_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int PAUSE      = 20;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        env_in = 1'b1;
  logic        frm_valid;
  logic [31:0] frm_data;
  logic [5:0]  frm_bits;

  int chk = 0;
  int fail = 0;
  int cyc = 0;
  int last_rise = 0;
  bit done = 0;

  logic [31:0] got_data[$];
  int          got_bits[$];
  int          got_dly[$];

  // behavioural reference state
  int   m_cnt = 3000;
  bit   m_prev = 1;
  bit   m_active = 0;
  bit   m_q[$];
  bit   e_valid = 0;
  logic [31:0] e_data = '0;
  int   e_bits = 0;

  pp_frame_decoder dut (
    .clk(clk), .rst_n(rst_n), .env_in(env_in),
    .frm_valid(frm_valid), .frm_data(frm_data), .frm_bits(frm_bits)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 3000; m_prev = 1; m_active = 0; m_q.delete(); e_valid = 0;
    end else begin
      bit r;
      r = env_in && !m_prev;
      m_prev = env_in;
      e_valid = 0;
      if (m_active && m_cnt >= 170) begin
        if (m_q.size() > 4) begin
          e_valid = 1;
          e_data = '0;
          foreach (m_q[i]) e_data[i] = m_q[i];
          e_bits = m_q.size();
        end
        m_q.delete();
        m_active = 0;
      end else if (r && m_cnt > 130 && m_cnt < 170) begin
        m_active = 1;
        if (m_q.size() < 32) m_q.push_back(1'b1);
      end else if (r && m_cnt > 70 && m_cnt < 110) begin
        m_active = 1;
        if (m_q.size() < 32) m_q.push_back(1'b0);
      end
      if (r) m_cnt = 1;
      else if (m_cnt < 3000) m_cnt = m_cnt + 1;
    end
  end

  // per-cycle comparison against the model, plus frame capture
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk++;
      if (frm_valid !== e_valid) begin
        fail++;
        $display("FAIL R5/R9: frm_valid=%0b expected %0b at cycle %0d", frm_valid, e_valid, cyc);
      end else if (frm_valid && (frm_data !== e_data || int'(frm_bits) != e_bits)) begin
        fail++;
        $display("FAIL R7: data=%h bits=%0d expected data=%h bits=%0d", frm_data, frm_bits, e_data, e_bits);
      end
      if (frm_valid) begin
        got_data.push_back(frm_data);
        got_bits.push_back(int'(frm_bits));
        got_dly.push_back(cyc - last_rise);
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", chk, fail);
  endtask

  always @(posedge clk) begin
    if (cyc > WATCHDOG && !done) begin
      done = 1;
      fail++;
      $display("FAIL watchdog: cycle %0d expected below %0d", cyc, WATCHDOG);
      summary();
      $finish;
    end
  end

  task automatic edge_after(input int iv);
    repeat (iv - PAUSE) @(negedge clk);
    env_in = 1'b0;
    repeat (PAUSE) @(negedge clk);
    env_in = 1'b1;
    last_rise = cyc + 1;
  endtask

  task automatic send_frame(input int n, input logic [63:0] pat);
    edge_after(400);
    for (int i = 0; i < n; i++) edge_after(pat[i] ? 150 : 90);
    repeat (300) @(negedge clk);
  endtask

  task automatic take_frame(input logic [31:0] ed, input int eb, input string tag);
    chk++;
    if (got_data.size() == 0) begin
      fail++;
      $display("FAIL %s: no frame, expected data=%h bits=%0d", tag, ed, eb);
    end else begin
      logic [31:0] d;
      int b, dl;
      d = got_data.pop_front(); b = got_bits.pop_front(); dl = got_dly.pop_front();
      if (d !== ed || b != eb) begin
        fail++;
        $display("FAIL %s: data=%h bits=%0d expected data=%h bits=%0d", tag, d, b, ed, eb);
      end
      chk++;
      if (dl != 170) begin
        fail++;
        $display("FAIL R5: close delay %0d expected 170", dl);
      end
    end
  endtask

  task automatic expect_none(input string tag);
    chk++;
    if (got_data.size() != 0) begin
      fail++;
      $display("FAIL %s: %0d frames emitted, expected 0", tag, got_data.size());
      got_data.delete(); got_bits.delete(); got_dly.delete();
    end
  endtask

  initial begin
    logic [63:0] pat;
    logic [31:0] exp32;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk++;
    if (frm_valid !== 1'b0 || frm_data !== '0 || frm_bits !== '0) begin
      fail++;
      $display("FAIL R1: valid=%0b data=%h bits=%0d expected 0 0 0", frm_valid, frm_data, frm_bits);
    end
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk++;
    if (frm_valid !== 1'b0 || frm_data !== '0 || frm_bits !== '0) begin
      fail++;
      $display("FAIL R1: after release valid=%0b data=%h bits=%0d expected 0 0 0", frm_valid, frm_data, frm_bits);
    end

    // R2 R3 R7: symbols 1,0,1,1,0,0,1,0 -> 0x4D
    send_frame(8, 64'b01001101);
    take_frame(32'h4D, 8, "R7 R2 R3 mixed frame");

    // R3 R4 boundaries: 131->1 169->1 71->0 109->0, 130/110/70 ignored, 150->1
    edge_after(400);
    edge_after(131); edge_after(169); edge_after(130); edge_after(71);
    edge_after(110); edge_after(109); edge_after(70);  edge_after(150);
    repeat (300) @(negedge clk);
    take_frame(32'h13, 5, "R4 R3 window edges, R6 five bits kept");

    // R6: four-bit frame dropped
    send_frame(4, 64'hF);
    expect_none("R6 four-bit frame");

    // R8: 40 symbols, one where i%3==0
    pat = '0; exp32 = '0;
    for (int i = 0; i < 40; i++) pat[i] = (i % 3 == 0);
    for (int i = 0; i < 32; i++) exp32[i] = (i % 3 == 0);
    send_frame(40, pat);
    take_frame(exp32, 32, "R8 cap at 32");

    // R9: next frame starts empty
    send_frame(6, 64'h3F);
    take_frame(32'h3F, 6, "R9 fresh accumulator");

    // R10: 4246-cycle idle marker is no symbol, then five ones
    edge_after(4246);
    for (int i = 0; i < 5; i++) edge_after(150);
    repeat (300) @(negedge clk);
    take_frame(32'h1F, 5, "R10 idle halt");
    expect_none("R9 no extra frames");

    done = 1;
    summary();
    $finish;
  end
endmodule